// File: doc/BRIEF.md
# Scratchpad Wraparound Transfer Engine

This block generates addresses for a pair of DMA directions that move 16-byte quadwords between a small on-chip scratchpad and external memory. One direction reads the scratchpad and writes outward; the other reads outward memory and fills the scratchpad. A start pulse supplies a direction, an external byte address and a quadword count. The engine then emits one address beat per quadword. Each beat carries a scratchpad address, a region code and an offset inside that region.

The scratchpad pointer is a register that software can write. It is kept quadword-aligned and inside the scratchpad. It steps by 16 for each beat and wraps to zero past the last quadword, so one transfer may run across the end of the scratchpad. The external address is classified once at start into main RAM or one of two vector-memory windows, and the offset then steps inside that region. When a transfer ends, the pointer register holds the final wrapped position, ready for the next transfer or for a read-back.

The beat output is a valid/ready stream. A beat is consumed only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the beat stays unchanged. `out_ready` may be held low for any number of cycles. `out_valid` never depends on `out_ready`.

Top module: `spad_xfer_engine`

## Requirements
- R1: After reset, `sp_ptr` is 0 and `out_valid`, `busy` and `done` are low.
- R2: A write on `sp_wr_en` loads `sp_ptr` with `sp_wr_data & (SP_BYTES-1) & ~15`, visible the next cycle; with defaults, 0x12345678 reads back as 0x1670. The write is ignored while `busy` is high.
- R3: Each handshake advances `out_sp_addr` by 16 and `out_ext_addr` by 16, and the next beat follows in the next cycle if `out_ready` stays high.
- R4: When a beat uses the last scratchpad quadword (SP_BYTES-16), the next beat uses scratchpad address 0, and the transfer continues.
- R5: An address in [WIN0_BASE, WIN0_BASE+WIN0_BYTES) gives region code 1 and offset (addr−WIN0_BASE)&(WIN0_BYTES−1), in both directions.
- R6: An address in [WIN1_BASE, WIN1_BASE+WIN1_BYTES) gives region code 2 and offset (addr−WIN1_BASE)&(WIN1_BYTES−1) only when `dir`=1 (external to scratchpad). When `dir`=0, the same address is treated as main RAM.
- R7: Any other address gives region code 0 and offset addr&(RAM_BYTES−1).
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sp_addr`, `out_ext_addr`, `out_region` and `out_last` hold their values.
- R9: A transfer of N>0 quadwords emits exactly N beats. `out_last` is high only on the N-th beat. `done` pulses for one cycle in the cycle after the final handshake, with `done_count`=N.
- R10: A start with count 0 emits no beat. `done` pulses in the next cycle with `done_count`=0, and `sp_ptr` is unchanged.
- R11: A start pulse while `busy` is high is ignored. The running transfer keeps its direction, addresses and count.
- R12: After `done`, `sp_ptr` equals the starting pointer plus 16·N, wrapped within the scratchpad.
- R13: The external offset wraps within its region mask. With defaults, window-0 offset 0xFF0 is followed by 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_wr_en | input | 1 | Write strobe for the scratchpad pointer |
| sp_wr_data | input | 32 | Value written to the scratchpad pointer (masked) |
| sp_ptr | output | 32 | Current scratchpad pointer, readable at any time |
| start | input | 1 | Starts a transfer when idle |
| dir | input | 1 | 0: scratchpad to external, 1: external to scratchpad |
| ext_addr | input | 32 | External start byte address |
| qw_count | input | CNT_W | Quadword count |
| busy | output | 1 | Transfer in progress |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Consumer accepts beat |
| out_sp_addr | output | 32 | Scratchpad byte address of the beat |
| out_ext_addr | output | 32 | Offset inside the decoded region |
| out_region | output | 2 | 0 main RAM, 1 window 0, 2 window 1 |
| out_last | output | 1 | Final beat of the transfer |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | CNT_W | Quadwords reported as moved |

## Verification
The hardest case to reach is a wrap of the scratchpad pointer mid-transfer while the consumer stalls. Another is a start or pointer write that lands while a transfer is still running. The bench reaches the first by writing a pointer three quadwords below the end, then starting a transfer longer than that, with `out_ready` toggling. It reaches the second by injecting a start and a pointer write on the second cycle of a running transfer. It then confirms, beat by beat and through the final pointer read-back, that neither had any effect.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int QW_BYTES = 16;

  localparam logic DIR_SP_TO_EXT = 1'b0;
  localparam logic DIR_EXT_TO_SP = 1'b1;

  typedef enum logic [1:0] {
    REG_MAIN = 2'd0,
    REG_WIN0 = 2'd1,
    REG_WIN1 = 2'd2
  } spx_region_e;

  typedef struct packed {
    spx_region_e region;
    logic [31:0] offset;
    logic [31:0] mask;
  } spx_loc_t;
endpackage

// File: rtl/spx_addr_decode.sv
module spx_addr_decode
  import spx_pkg::*;
#(
  parameter int unsigned RAM_BYTES  = 32'h0200_0000,
  parameter logic [31:0] WIN0_BASE  = 32'h1100_0000,
  parameter int unsigned WIN0_BYTES = 4096,
  parameter logic [31:0] WIN1_BASE  = 32'h1100_8000,
  parameter int unsigned WIN1_BYTES = 16384
) (
  input  logic        dir,
  input  logic [31:0] addr,
  output spx_loc_t    loc
);
  localparam logic [32:0] W0_LO = {1'b0, WIN0_BASE};
  localparam logic [32:0] W0_HI = W0_LO + 33'(WIN0_BYTES);
  localparam logic [32:0] W1_LO = {1'b0, WIN1_BASE};
  localparam logic [32:0] W1_HI = W1_LO + 33'(WIN1_BYTES);
  localparam logic [31:0] RAM_MASK = 32'(RAM_BYTES - 1);
  localparam logic [31:0] W0_MASK  = 32'(WIN0_BYTES - 1);
  localparam logic [31:0] W1_MASK  = 32'(WIN1_BYTES - 1);

  logic [32:0] a33;
  logic        hit0, hit1;

  assign a33  = {1'b0, addr};
  assign hit0 = (a33 >= W0_LO) && (a33 < W0_HI);
  // the second window is decoded only when filling the scratchpad
  assign hit1 = (dir == DIR_EXT_TO_SP) && (a33 >= W1_LO) && (a33 < W1_HI);

  always_comb begin
    if (hit0) begin
      loc.region = REG_WIN0;
      loc.offset = (addr - WIN0_BASE) & W0_MASK;
      loc.mask   = W0_MASK;
    end else if (hit1) begin
      loc.region = REG_WIN1;
      loc.offset = (addr - WIN1_BASE) & W1_MASK;
      loc.mask   = W1_MASK;
    end else begin
      loc.region = REG_MAIN;
      loc.offset = addr & RAM_MASK;
      loc.mask   = RAM_MASK;
    end
  end
endmodule

// File: rtl/spx_sp_pointer.sv
module spx_sp_pointer
  import spx_pkg::*;
#(
  parameter int unsigned SP_BYTES = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        adv,
  output logic [31:0] ptr
);
  localparam logic [31:0] SP_MASK = 32'(SP_BYTES - 1) & ~32'hF;

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (wr_en)  ptr <= wr_data & SP_MASK;
    else if (adv)    ptr <= (ptr + 32'(QW_BYTES)) & SP_MASK;
  end

  // R2
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr & ~SP_MASK) == 32'h0);
  // R4
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wr_en && ptr == SP_MASK) |=> ptr == 32'h0);
endmodule

// File: rtl/spx_beat_ctrl.sv
module spx_beat_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             ready,
  output logic             valid,
  output logic             last,
  output logic             busy,
  output logic             fire,
  output logic             accept,
  output logic             done,
  output logic [CNT_W-1:0] done_count
);
  logic             run;
  logic [CNT_W-1:0] remain;

  assign valid  = run;
  assign busy   = run;
  assign fire   = run & ready;
  assign accept = start & ~run;
  assign last   = run && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      remain     <= '0;
      done       <= 1'b0;
      done_count <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        done_count <= count;
        if (count == '0) done <= 1'b1;
        else begin
          run    <= 1'b1;
          remain <= count;
        end
      end else if (fire) begin
        remain <= remain - CNT_W'(1);
        if (remain == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid && $stable(remain));
  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start) |=> $stable(done_count));
endmodule

// File: rtl/spad_xfer_engine.sv
module spad_xfer_engine
  import spx_pkg::*;
#(
  parameter int unsigned SP_BYTES   = 16384,
  parameter int unsigned RAM_BYTES  = 32'h0200_0000,
  parameter logic [31:0] WIN0_BASE  = 32'h1100_0000,
  parameter int unsigned WIN0_BYTES = 4096,
  parameter logic [31:0] WIN1_BASE  = 32'h1100_8000,
  parameter int unsigned WIN1_BYTES = 16384,
  parameter int          CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sp_wr_en,
  input  logic [31:0]      sp_wr_data,
  output logic [31:0]      sp_ptr,
  input  logic             start,
  input  logic             dir,
  input  logic [31:0]      ext_addr,
  input  logic [CNT_W-1:0] qw_count,
  output logic             busy,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_sp_addr,
  output logic [31:0]      out_ext_addr,
  output logic [1:0]       out_region,
  output logic             out_last,
  output logic             done,
  output logic [CNT_W-1:0] done_count
);
  spx_loc_t    loc;
  logic        fire, accept;
  logic        dir_q;
  spx_region_e region_q;
  logic [31:0] off_q, mask_q;

  spx_addr_decode #(
    .RAM_BYTES (RAM_BYTES),
    .WIN0_BASE (WIN0_BASE),
    .WIN0_BYTES(WIN0_BYTES),
    .WIN1_BASE (WIN1_BASE),
    .WIN1_BYTES(WIN1_BYTES)
  ) u_dec (
    .dir (dir),
    .addr(ext_addr),
    .loc (loc)
  );

  spx_beat_ctrl #(.CNT_W(CNT_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .count     (qw_count),
    .ready     (out_ready),
    .valid     (out_valid),
    .last      (out_last),
    .busy      (busy),
    .fire      (fire),
    .accept    (accept),
    .done      (done),
    .done_count(done_count)
  );

  spx_sp_pointer #(.SP_BYTES(SP_BYTES)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sp_wr_en & ~busy),
    .wr_data(sp_wr_data),
    .adv    (fire),
    .ptr    (sp_ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q    <= DIR_SP_TO_EXT;
      region_q <= REG_MAIN;
      off_q    <= '0;
      mask_q   <= '0;
    end else if (accept) begin
      dir_q    <= dir;
      region_q <= loc.region;
      off_q    <= loc.offset;
      mask_q   <= loc.mask;
    end else if (fire) begin
      off_q <= (off_q + 32'(QW_BYTES)) & mask_q;
    end
  end

  assign out_sp_addr  = sp_ptr;
  assign out_ext_addr = off_q;
  assign out_region   = region_q;

  // R8
  beat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_sp_addr)
      && $stable(out_ext_addr) && $stable(out_region) && $stable(out_last));
  // R6
  win1_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_region == 2'd2) |-> dir_q == DIR_EXT_TO_SP);
endmodule

// File: tb/sim_spad_xfer_engine.sv
module sim_spad_xfer_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int          CW    = 16;
  localparam logic [31:0] SPM   = 32'h0000_3FF0;
  localparam logic [31:0] RAMM  = 32'h01FF_FFFF;
  localparam logic [31:0] W0B   = 32'h1100_0000;
  localparam logic [31:0] W0M   = 32'h0000_0FFF;
  localparam logic [31:0] W1B   = 32'h1100_8000;
  localparam logic [31:0] W1M   = 32'h0000_3FFF;

  logic clk = 0, rst_n = 0;
  logic sp_wr_en = 0, start = 0, dir = 0, out_ready = 0;
  logic [31:0] sp_wr_data = 0, ext_addr = 0;
  logic [CW-1:0] qw_count = 0;
  logic [31:0] sp_ptr, out_sp_addr, out_ext_addr;
  logic busy, out_valid, out_last, done;
  logic [1:0] out_region;
  logic [CW-1:0] done_count;

  int n_tot = 0, n_fail = 0;
  logic [31:0] sp_model = 0;

  always #4 clk = ~clk;

  spad_xfer_engine #(.SP_BYTES(16384), .RAM_BYTES(32'h0200_0000),
    .WIN0_BASE(W0B), .WIN0_BYTES(4096), .WIN1_BASE(W1B),
    .WIN1_BYTES(16384), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
    .sp_ptr(sp_ptr), .start(start), .dir(dir), .ext_addr(ext_addr),
    .qw_count(qw_count), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_sp_addr(out_sp_addr),
    .out_ext_addr(out_ext_addr), .out_region(out_region),
    .out_last(out_last), .done(done), .done_count(done_count));

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] e_reg(input logic d, input logic [31:0] a);
    if (a >= W0B && a - W0B <= W0M) return 2'd1;
    if (d && a >= W1B && a - W1B <= W1M) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [31:0] e_mask(input logic [1:0] r);
    return (r == 2'd1) ? W0M : (r == 2'd2) ? W1M : RAMM;
  endfunction

  function automatic logic [31:0] e_off(input logic [1:0] r, input logic [31:0] a);
    return (r == 2'd1) ? ((a - W0B) & W0M) : (r == 2'd2) ? ((a - W1B) & W1M) : (a & RAMM);
  endfunction

  task automatic t_reset;
    chk(sp_ptr == 0, "R1", "sp_ptr", sp_ptr, 0);
    chk(!out_valid && !busy && !done, "R1", "valid/busy/done", {out_valid, busy, done}, 0);
  endtask

  task automatic t_ptr_write(input logic [31:0] v);
    @(negedge clk); sp_wr_en = 1; sp_wr_data = v;
    @(negedge clk); sp_wr_en = 0;
    sp_model = v & SPM;
    chk(sp_ptr == sp_model, "R2", "pointer write", sp_ptr, sp_model);
  endtask

  task automatic t_xfer(input logic d, input logic [31:0] a, input int n,
                        input int stall, input bit poke, input string rq);
    logic [1:0] er; logic [31:0] eo, em, se; int got, cyc;
    er = e_reg(d, a); em = e_mask(er); eo = e_off(er, a); se = sp_model;
    @(negedge clk); dir = d; ext_addr = a; qw_count = CW'(n); start = 1;
    @(negedge clk); start = 0;
    got = 0; cyc = 0;
    while (got < n && cyc < 2000) begin
      out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (poke && cyc == 1) begin
        start = 1; dir = ~d; ext_addr = 32'h0000_0400; qw_count = 7;
        sp_wr_en = 1; sp_wr_data = 32'h0000_2220;
      end else begin
        start = 0; sp_wr_en = 0;
      end
      chk(out_valid, rq, "R3 valid", {31'b0, out_valid}, 1);
      chk(out_sp_addr == se, rq, "R3/R4 sp addr", out_sp_addr, se);
      chk(out_ext_addr == eo, rq, "R3/R13 ext offset", out_ext_addr, eo);
      chk(out_region == er, rq, "R5/R6/R7 region", {30'b0, out_region}, {30'b0, er});
      chk(out_last == (got == n - 1), rq, "R9 last", {31'b0, out_last},
          {31'b0, (got == n - 1)});
      if (out_ready) begin
        got++; se = (se + 16) & SPM; eo = (eo + 16) & em;
      end
      cyc++;
      @(negedge clk);
    end
    start = 0; sp_wr_en = 0; out_ready = 0;
    chk(done, rq, "R9 done pulse", {31'b0, done}, 1);
    chk(done_count == CW'(n), rq, "R9 done_count", 32'(done_count), 32'(n));
    chk(!out_valid && !busy, rq, "R9 idle after", {out_valid, busy}, 0);
    sp_model = se;
    chk(sp_ptr == sp_model, rq, "R12 final pointer", sp_ptr, sp_model);
    @(negedge clk);
    chk(!done, rq, "R9 single pulse", {31'b0, done}, 0);
  endtask

  task automatic t_zero;
    @(negedge clk); dir = 1; ext_addr = 32'h100; qw_count = 0; start = 1;
    @(negedge clk); start = 0;
    chk(done && done_count == 0, "R10", "zero done", 32'(done_count), 0);
    chk(!out_valid && !busy, "R10", "zero no beat", {out_valid, busy}, 0);
    chk(sp_ptr == sp_model, "R10", "zero ptr", sp_ptr, sp_model);
    @(negedge clk);
    chk(!done && !out_valid, "R10", "zero quiet", {done, out_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ptr_write(32'h1234_5678);
    chk(sp_ptr == 32'h1670, "R2", "masked literal", sp_ptr, 32'h1670);
    t_ptr_write(32'h0000_3FC8);
    t_xfer(1'b1, 32'h0000_1000, 5, 3, 0, "R4");
    t_xfer(1'b0, W0B + 32'hFF0, 2, 0, 0, "R5");
    t_xfer(1'b1, W0B + 32'h200, 3, 2, 0, "R5");
    t_xfer(1'b1, W1B + 32'h10, 4, 4, 0, "R6");
    t_xfer(1'b0, W1B + 32'h10, 2, 0, 0, "R6");
    t_xfer(1'b0, 32'h0380_0040, 3, 0, 0, "R7");
    t_zero();
    t_xfer(1'b1, 32'h0000_2000, 4, 0, 1, "R11");
    chk(sp_ptr != 32'h2220, "R2", "write while busy ignored", sp_ptr, sp_model);
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_tot++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule